// File: doc/BRIEF.md
# Boot Mode Sequencer

This block takes the place of a boot-ROM loop. It holds the processor's fetch-enable low after reset and selects one of three ways to start the processor. Two strap pins choose the path, and they are read once, right after reset.

- **Debug wait:** the sequencer idles until a debugger (or a bench that has preloaded memory) sets a ready flag. It then starts the processor at the address held in a writable boot-address register.
- **Execute in place:** the processor starts at once inside the memory-mapped flash window, at the entry offset.
- **Load:** the first 1 KB of flash is copied word by word into RAM, and the processor then starts at the RAM entry offset.

The copy issues one word-read request at a time toward a flash reader. It waits for that word's response and writes the word into a RAM write port, which is indexed by word. When the chosen path completes, fetch-enable rises together with a start PC. Both stay fixed until the next reset.

Top module: `boot_seq_top`

## Requirements
- R1: With `strap_boot_i` = 0 the debug-wait path is taken whatever `strap_xip_i` holds. No flash request and no RAM write occur on this path.
- R2: With `strap_boot_i` = 1 and `strap_xip_i` = 1, `fetch_en_o` is high after the first clock edge with reset low. `start_pc_o` is then 0x4000_0180 (flash window base 0x4000_0000 plus entry 0x180), and no flash request or RAM write occurs.
- R3: The strap pins are sampled only on the first edge with reset low. Later changes to them do not alter the path taken.
- R4: In debug wait, `fetch_en_o` stays low until the ready flag is set. It rises on the edge after the flag-setting write, and `start_pc_o` then equals the boot-address register.
- R5: The register bus decodes byte offset 0 as the boot-address register (reset value 0x180) and offset 4 as the ready flag, read in bit 0. A read returns the value of the addressed register one edge after `reg_addr_i` is presented.
- R6: The ready flag is write-1-to-set on bit 0 of the write data. A write with bit 0 = 0 leaves it unchanged, and only reset clears it.
- R7: With `strap_boot_i` = 1 and `strap_xip_i` = 0, exactly 256 flash requests are issued. Request i carries byte offset 4*i. Each request is a single-cycle pulse, and the next one is issued only after the response to the previous one.
- R8: Each accepted response produces one RAM write on the next edge. Write i goes to word index i and carries the data of response i.
- R9: After the load, `fetch_en_o` rises one edge after the last RAM write, with `start_pc_o` = 0x0000_0180.
- R10: Once `fetch_en_o` is high it stays high, and `start_pc_o` stays stable, until reset. From then on no flash request or RAM write is issued.
- R11: `fl_rvalid_i` is ignored in any cycle where no request is outstanding, including the cycle in which a request is being issued. Such a pulse causes no RAM write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_boot_i | input | 1 | Strap: 0 selects debug wait, 1 selects a flash path |
| strap_xip_i | input | 1 | Strap: with `strap_boot_i` = 1, 1 selects execute in place and 0 selects load |
| reg_we_i | input | 1 | Register bus write strobe |
| reg_addr_i | input | 3 | Register bus byte offset |
| reg_wdata_i | input | 32 | Register bus write data |
| reg_rdata_o | output | 32 | Register bus read data, registered |
| fl_req_o | output | 1 | Flash word-read request pulse |
| fl_addr_o | output | 24 | Flash byte offset of the request |
| fl_rvalid_i | input | 1 | Flash response valid |
| fl_rdata_i | input | 32 | Flash response word |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | 8 | RAM word index |
| ram_wdata_o | output | 32 | RAM write data |
| fetch_en_o | output | 1 | Processor fetch enable |
| start_pc_o | output | 32 | Processor start address |

## Verification
Every strap combination is tried, including both values of the ignored pin in debug mode and strap changes after sampling. The results distinguish the three paths by their start PC, their release timing and whether any flash traffic appears. The debug path is driven with random wait lengths and random boot addresses, plus a zero-bit-0 flag write, which shows that release follows the flag rather than time or a stray write. Loads run with random response latency of zero to three extra cycles, with and without stray valid pulses. This shows the copy is paced by responses, keeps the offset order, and does not treat an unrequested valid as data.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  typedef enum logic [1:0] {
    BM_DEBUG = 2'd0,
    BM_XIP   = 2'd1,
    BM_LOAD  = 2'd2
  } boot_mode_e;

  typedef enum logic [1:0] {
    SQ_SAMPLE = 2'd0,
    SQ_HOLD   = 2'd1,
    SQ_COPY   = 2'd2,
    SQ_RUN    = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    CP_IDLE = 2'd0,
    CP_WAIT = 2'd1,
    CP_END  = 2'd2
  } copy_state_e;

  function automatic boot_mode_e decode_mode(input logic boot_pin, input logic xip_pin);
    if (!boot_pin) return BM_DEBUG;
    if (xip_pin)   return BM_XIP;
    return BM_LOAD;
  endfunction

endpackage

// File: rtl/boot_regs.sv
module boot_regs #(
  parameter int          REG_AW   = 3,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] ADDR_RST = 32'h0000_0180
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] boot_addr,
  output logic              ready
);
  localparam logic [REG_AW-1:0] OFS_ADDR = REG_AW'(0);
  localparam logic [REG_AW-1:0] OFS_FLAG = REG_AW'(4);

  always_ff @(posedge clk) begin
    if (rst) begin
      boot_addr <= DATA_W'(ADDR_RST);
      ready     <= 1'b0;
      rdata     <= '0;
    end else begin
      if (we && addr == OFS_ADDR) boot_addr <= wdata;
      if (we && addr == OFS_FLAG && wdata[0]) ready <= 1'b1;
      if (addr == OFS_ADDR)      rdata <= boot_addr;
      else if (addr == OFS_FLAG) rdata <= DATA_W'(ready);
      else                       rdata <= '0;
    end
  end
endmodule

// File: rtl/boot_copy.sv
module boot_copy
  import boot_seq_pkg::*;
#(
  parameter int WORDS    = 256,
  parameter int FLASH_AW = 24,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  output logic                req,
  output logic [FLASH_AW-1:0] req_addr,
  input  logic                rvalid,
  input  logic [DATA_W-1:0]   rdata,
  output logic                ram_we,
  output logic [IDX_W-1:0]    ram_addr,
  output logic [DATA_W-1:0]   ram_wdata,
  output logic                done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

  copy_state_e      st;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] idx_nxt;
  logic             take;

  assign idx_nxt = idx + 1'b1;
  // a response counts only while one is outstanding and no new request is on the wire
  assign take    = (st == CP_WAIT) && rvalid && !req;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= CP_IDLE;
      idx       <= '0;
      req       <= 1'b0;
      req_addr  <= '0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      done      <= 1'b0;
    end else begin
      req    <= 1'b0;
      ram_we <= 1'b0;
      case (st)
        CP_IDLE: begin
          if (start) begin
            idx      <= '0;
            req      <= 1'b1;
            req_addr <= '0;
            st       <= CP_WAIT;
          end
        end
        CP_WAIT: begin
          if (take) begin
            ram_we    <= 1'b1;
            ram_addr  <= idx;
            ram_wdata <= rdata;
            if (idx == LAST) begin
              st   <= CP_END;
              done <= 1'b1;
            end else begin
              idx      <= idx_nxt;
              req      <= 1'b1;
              req_addr <= FLASH_AW'({idx_nxt, 2'b00});
            end
          end
        end
        default: st <= CP_END;
      endcase
    end
  end
endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top
  import boot_seq_pkg::*;
#(
  parameter int          REG_AW    = 3,
  parameter int          DATA_W    = 32,
  parameter int          FLASH_AW  = 24,
  parameter int          COPY_WORDS = 256,
  parameter logic [31:0] XIP_BASE  = 32'h4000_0000,
  parameter logic [31:0] RAM_BASE  = 32'h0000_0000,
  parameter logic [31:0] ENTRY_OFS = 32'h0000_0180,
  parameter logic [31:0] ADDR_RST  = 32'h0000_0180,
  localparam int         RAM_AW    = $clog2(COPY_WORDS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                strap_boot_i,
  input  logic                strap_xip_i,
  input  logic                reg_we_i,
  input  logic [REG_AW-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic                fl_req_o,
  output logic [FLASH_AW-1:0] fl_addr_o,
  input  logic                fl_rvalid_i,
  input  logic [DATA_W-1:0]   fl_rdata_i,
  output logic                ram_we_o,
  output logic [RAM_AW-1:0]   ram_addr_o,
  output logic [DATA_W-1:0]   ram_wdata_o,
  output logic                fetch_en_o,
  output logic [DATA_W-1:0]   start_pc_o
);
  localparam logic [DATA_W-1:0] XIP_PC  = DATA_W'(XIP_BASE + ENTRY_OFS);
  localparam logic [DATA_W-1:0] LOAD_PC = DATA_W'(RAM_BASE + ENTRY_OFS);

  seq_state_e        st;
  logic              copy_go;
  logic              copy_done;
  logic              ready;
  logic [DATA_W-1:0] boot_addr;

  boot_regs #(.REG_AW(REG_AW), .DATA_W(DATA_W), .ADDR_RST(ADDR_RST)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we_i), .addr(reg_addr_i), .wdata(reg_wdata_i),
    .rdata(reg_rdata_o), .boot_addr(boot_addr), .ready(ready)
  );

  boot_copy #(.WORDS(COPY_WORDS), .FLASH_AW(FLASH_AW), .DATA_W(DATA_W)) u_copy (
    .clk(clk), .rst(rst), .start(copy_go),
    .req(fl_req_o), .req_addr(fl_addr_o), .rvalid(fl_rvalid_i), .rdata(fl_rdata_i),
    .ram_we(ram_we_o), .ram_addr(ram_addr_o), .ram_wdata(ram_wdata_o), .done(copy_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= SQ_SAMPLE;
      copy_go    <= 1'b0;
      fetch_en_o <= 1'b0;
      start_pc_o <= '0;
    end else begin
      copy_go <= 1'b0;
      case (st)
        SQ_SAMPLE: begin
          case (decode_mode(strap_boot_i, strap_xip_i))
            BM_XIP: begin
              st         <= SQ_RUN;
              fetch_en_o <= 1'b1;
              start_pc_o <= XIP_PC;
            end
            BM_LOAD: begin
              st      <= SQ_COPY;
              copy_go <= 1'b1;
            end
            default: st <= SQ_HOLD;
          endcase
        end
        SQ_HOLD: begin
          if (ready) begin
            st         <= SQ_RUN;
            fetch_en_o <= 1'b1;
            start_pc_o <= boot_addr;
          end
        end
        SQ_COPY: begin
          if (copy_done) begin
            st         <= SQ_RUN;
            fetch_en_o <= 1'b1;
            start_pc_o <= LOAD_PC;
          end
        end
        default: st <= SQ_RUN;
      endcase
    end
  end
endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_en_o,
  input logic [DATA_W-1:0] start_pc_o,
  input logic              fl_req_o,
  input logic              fl_rvalid_i,
  input logic              ram_we_o
);
  assert_en_hold_R10: assert property (@(posedge clk) disable iff (rst)
    fetch_en_o |=> fetch_en_o);

  assert_pc_hold_R10: assert property (@(posedge clk) disable iff (rst)
    fetch_en_o |=> $stable(start_pc_o));

  assert_quiet_after_R10: assert property (@(posedge clk) disable iff (rst)
    fetch_en_o |-> (!ram_we_o && !fl_req_o));

  assert_one_outstanding_R7: assert property (@(posedge clk) disable iff (rst)
    fl_req_o |=> !fl_req_o);

  // R8 and R11: a RAM write follows an accepted response, never one that coincided with a request
  assert_write_after_rsp_R8: assert property (@(posedge clk) disable iff (rst)
    ram_we_o |-> $past(fl_rvalid_i && !fl_req_o));
endmodule

bind boot_seq_top boot_seq_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_boot_seq_top.sv
module sim_boot_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strap_boot_i = 1'b0, strap_xip_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        fl_req_o;
  logic [23:0] fl_addr_o;
  logic        fl_rvalid_i = 1'b0;
  logic [31:0] fl_rdata_i = '0;
  logic        ram_we_o;
  logic [7:0]  ram_addr_o;
  logic [31:0] ram_wdata_o;
  logic        fetch_en_o;
  logic [31:0] start_pc_o;

  int checks = 0, errors = 0;
  int req_cnt, ram_cnt, cyc, last_we_cyc, fetch_cyc;
  bit pending, spur_en = 0, fetch_seen;
  int lat;
  logic [23:0] pend_addr;
  logic [31:0] mem [WORDS];

  boot_seq_top u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] fdat(input logic [23:0] a);
    return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // flash reader model with random latency and optional stray valid pulses
  always @(posedge clk) begin
    fl_rvalid_i <= 1'b0;
    if (rst) begin
      pending <= 1'b0;
    end else if (pending) begin
      if (lat == 0) begin
        fl_rvalid_i <= 1'b1;
        fl_rdata_i  <= fdat(pend_addr);
        pending     <= 1'b0;
      end else lat <= lat - 1;
    end else if (fl_req_o) begin
      pending   <= 1'b1;
      pend_addr <= fl_addr_o;
      lat       <= int'($urandom % 4);
    end else if (spur_en && ($urandom % 3 == 0)) begin
      fl_rvalid_i <= 1'b1;
      fl_rdata_i  <= 32'hDEAD_BEEF;
    end
  end

  // traffic monitor
  always @(posedge clk) begin
    if (rst) begin
      req_cnt <= 0; ram_cnt <= 0; cyc <= 0; last_we_cyc <= -1; fetch_cyc <= -1; fetch_seen <= 0;
    end else begin
      cyc <= cyc + 1;
      if (fl_req_o) begin
        chk(fl_addr_o == 24'(req_cnt * 4), "R7 request offset", 32'(fl_addr_o), 32'(req_cnt * 4));
        chk(!pending, "R7 request while outstanding", 32'(pending), 32'd0);
        req_cnt <= req_cnt + 1;
      end
      if (ram_we_o) begin
        chk(ram_addr_o == 8'(ram_cnt), "R8 write index", 32'(ram_addr_o), 32'(ram_cnt));
        chk(ram_wdata_o == fdat({14'd0, ram_addr_o, 2'b00}), "R8/R11 write data",
            ram_wdata_o, fdat({14'd0, ram_addr_o, 2'b00}));
        mem[ram_addr_o] <= ram_wdata_o;
        ram_cnt <= ram_cnt + 1;
        last_we_cyc <= cyc;
      end
      if (fetch_en_o && !fetch_seen) begin
        fetch_seen <= 1;
        fetch_cyc  <= cyc;
      end
    end
  end

  task automatic do_reset(input logic b, input logic x);
    @(negedge clk);
    rst = 1'b1; strap_boot_i = b; strap_xip_i = x; reg_we_i = 0;
    for (int i = 0; i < WORDS; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!fetch_en_o && start_pc_o == 0, "R10 reset state fetch/pc", {31'd0, fetch_en_o}, 32'd0);
    chk(!fl_req_o && !ram_we_o, "R7 reset state no traffic", {30'd0, fl_req_o, ram_we_o}, 32'd0);
    rst = 1'b0;
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1;
    @(posedge clk); @(negedge clk);
    reg_we_i = 0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    reg_addr_i = a;
    @(posedge clk); @(negedge clk);
    d = reg_rdata_o;
  endtask

  task automatic run_xip();
    logic [31:0] pc0;
    do_reset(1, 1);
    @(posedge clk); @(negedge clk);
    chk(fetch_en_o == 1, "R2 fetch after first edge", {31'd0, fetch_en_o}, 32'd1);
    chk(start_pc_o == 32'h4000_0180, "R2 start pc", start_pc_o, 32'h4000_0180);
    pc0 = start_pc_o;
    strap_boot_i = 0; strap_xip_i = 0;
    spur_en = 1;
    repeat (12) @(negedge clk);
    spur_en = 0;
    chk(fetch_en_o && start_pc_o == pc0, "R3 late strap change ignored", start_pc_o, pc0);
    chk(req_cnt == 0 && ram_cnt == 0, "R2/R11 no traffic in xip", 32'(req_cnt + ram_cnt), 32'd0);
  endtask

  task automatic run_debug(input logic x);
    logic [31:0] rd, ba;
    do_reset(0, x);
    reg_read(3'd0, rd);
    chk(rd == 32'h180, "R5 boot address reset", rd, 32'h180);
    reg_read(3'd4, rd);
    chk(rd == 0, "R5 flag reset", rd, 32'd0);
    spur_en = 1;
    strap_boot_i = 1; strap_xip_i = ~x;
    repeat (5 + $urandom % 30) @(negedge clk);
    chk(fetch_en_o == 0, "R4 waits for flag", {31'd0, fetch_en_o}, 32'd0);
    reg_write(3'd4, 32'hFFFF_FFFE);
    reg_read(3'd4, rd);
    chk(rd == 0, "R6 bit0 zero write ignored", rd, 32'd0);
    chk(fetch_en_o == 0, "R6 no release on zero write", {31'd0, fetch_en_o}, 32'd0);
    ba = $urandom & 32'hFFFF_FFFC;
    reg_write(3'd0, ba);
    reg_read(3'd0, rd);
    chk(rd == ba, "R5 boot address readback", rd, ba);
    reg_addr_i = 3'd4; reg_wdata_i = 32'd1; reg_we_i = 1;
    @(posedge clk); @(negedge clk);
    reg_we_i = 0;
    chk(fetch_en_o == 0, "R4 not yet on write edge", {31'd0, fetch_en_o}, 32'd0);
    @(negedge clk);
    chk(fetch_en_o == 1, "R4 release one edge after flag", {31'd0, fetch_en_o}, 32'd1);
    chk(start_pc_o == ba, "R4 start pc from register", start_pc_o, ba);
    reg_write(3'd4, 32'd0);
    reg_read(3'd4, rd);
    chk(rd == 1, "R6 flag stays set", rd, 32'd1);
    reg_write(3'd0, ~ba);
    repeat (3) @(negedge clk);
    chk(start_pc_o == ba, "R10 pc fixed after release", start_pc_o, ba);
    spur_en = 0;
    chk(req_cnt == 0 && ram_cnt == 0, "R1/R11 no traffic in debug", 32'(req_cnt + ram_cnt), 32'd0);
  endtask

  task automatic run_load(input bit spur);
    int guard, bad;
    do_reset(1, 0);
    spur_en = spur;
    @(posedge clk); @(negedge clk);
    strap_boot_i = 0;
    guard = 0;
    while (!fetch_en_o && guard < 4000) begin
      @(negedge clk); guard++;
      if (guard == 50) chk(fetch_en_o == 0, "R3 load continues after strap change", {31'd0, fetch_en_o}, 32'd0);
    end
    spur_en = 0;
    repeat (4) @(negedge clk);
    chk(fetch_en_o == 1, "R9 load completes", {31'd0, fetch_en_o}, 32'd1);
    chk(start_pc_o == 32'h180, "R9 start pc", start_pc_o, 32'h180);
    chk(req_cnt == WORDS, "R7 request count", 32'(req_cnt), 32'(WORDS));
    chk(ram_cnt == WORDS, "R8 write count", 32'(ram_cnt), 32'(WORDS));
    chk(fetch_cyc == last_we_cyc + 1, "R9 release after last write", 32'(fetch_cyc), 32'(last_we_cyc + 1));
    bad = 0;
    for (int i = 0; i < WORDS; i++) if (mem[i] != fdat(24'(i * 4))) bad++;
    chk(bad == 0, "R8 ram image", 32'(bad), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    run_xip();
    run_debug(1);
    run_debug(0);
    run_load(0);
    run_load(1);
    for (int t = 0; t < 3; t++) begin
      case ($urandom % 3)
        0: run_xip();
        1: run_debug(1'($urandom));
        default: run_load(1'($urandom));
      endcase
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule